// File: doc/BRIEF.md
# MDIO Station-Management Master

This block lets software reach the management registers of an external Ethernet PHY over the two-wire management bus. It generates the management clock (MDC) and drives or releases the bidirectional data line (MDIO). It serialises clause-22 frames and captures the data that the PHY returns on a read. Software sees two 32-bit words on a simple register bus. The command word holds the PHY and register addresses, the direction, a clock-divider code and a start/busy flag. The data word holds the value to send on a write, and it receives the value captured on a read.

A typical write sequence has three steps. Software loads the data word, then writes the command word with the start bit set, then polls the command word until the busy flag drops. A read uses the same sequence, except that the result is taken from the data word afterwards. A frame always runs for a fixed number of MDC periods, so busy clears after a bounded time even when no PHY answers. Setting the abort bit returns the controller to its idle state at once.

Top module: `mdio_mgmt_top`

## Requirements
- R1: After reset, the command word (bus address 0x0) reads 0x0030_0000, which is divider code 3 and all other fields zero. The data word (bus address 0x4) reads 0, MDC is low and the MDIO output enable is low.
- R2: The command word bit fields are as follows.
  - Bit 0: start on write, busy on read.
  - Bit 1: direction, where 1 is a PHY write and 0 is a PHY read.
  - Bits 10:4: register address, 7 bits.
  - Bits 16:12: PHY address, 5 bits.
  - Bits 22:20: divider code.
  - Writing the word while idle stores these fields. All other bits read 0.
- R3: A write frame carries 64 bits, sent MSB-first. Each bit is valid at a rising MDC edge. The bits are, in order:
  - 32 ones;
  - the start pattern 0,1;
  - the opcode 0,1;
  - the 5-bit PHY address;
  - the low 5 bits of the register address;
  - the turnaround 1,0;
  - the 16 data bits.
  The output enable stays high for the whole write frame.
- R4: A read frame sends the opcode 1,0. The output enable stays low from the first turnaround bit (bit 47 of the frame, counted from 1) to the end of the frame. MDIO is sampled at the 16 rising MDC edges of the data phase, MSB first, and the captured value is placed in the data word when the frame completes.
- R5: MDIO and its output enable never change while MDC is high. MDC is low whenever busy is 0.
- R6: The MDC period in clock cycles is set by the divider code: 0→42, 1→62, 2→16, 3→26, 4→102, 5→124, 6→124, 7→124. The high phase lasts half the period.
- R7: Busy is set at the clock edge that accepts a start. It clears exactly 64 MDC periods later, whatever the PHY drives.
- R8: A command-word write that does not set bit 2 is ignored while busy is 1. The stored fields are unchanged, no second frame starts, and the running frame is unaffected.
- R9: A write to the data word during a frame does not change the bits of that frame. After a write frame, the data word holds the value written last.
- R10: A command-word write with bit 2 set aborts any frame. One cycle later, busy, MDC and the output enable are 0 and the fields are back to their reset values. No frame starts, even when bit 0 was also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, the source of MDC |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | Access is a write |
| bus_addr_i | input | 3 | Byte address: 0x0 command, 0x4 data |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable, 1 = master drives |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The bench compares every bit of each frame with a queue of expected bits, and checks the MDC period and high time for each of the eight divider codes. A decoder that swapped two table entries, or treated the reserved codes as anything but /124, would show up as a wrong period or a wrong frame length. Several events are injected in the middle of a frame: a second command, a write to the data word, and an abort. A design that restarted or re-latched its frame would emit bits that differ from the queue. An abort that left MDC toggling would produce an unexpected clock edge. The read frames are answered by a PHY model, and the captured word is checked for an off-by-one in the sampling window and for a reversed bit order.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int BUS_W     = 32;
  localparam int DATA_W    = 16;
  localparam int PHY_W     = 5;
  localparam int REG_W     = 7;
  localparam int FREG_W    = 5;
  localparam int CODE_W    = 3;
  localparam int FRAME_LEN = 64;
  localparam int MAX_DIV   = 124;

  localparam int BUSY_BIT = 0;
  localparam int DIR_BIT  = 1;
  localparam int ABORT_BIT = 2;
  localparam int REG_LSB  = 4;
  localparam int PHY_LSB  = 12;
  localparam int CODE_LSB = 20;

  // non-monotonic divider table, reserved codes fall back to slowest
  function automatic int unsigned div_ratio(logic [CODE_W-1:0] code);
    case (code)
      3'd0:    return 42;
      3'd1:    return 62;
      3'd2:    return 16;
      3'd3:    return 26;
      3'd4:    return 102;
      default: return 124;
    endcase
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
  import mdio_pkg::*;
#(
  parameter int CNT_W = $clog2(MAX_DIV / 2 + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              mdc_o,
  output logic              rise_o,
  output logic              fall_o
);
  logic [CNT_W-1:0] cnt_q, half;
  logic             mdc_q, term;

  assign half = CNT_W'(div_ratio(code_i) >> 1);
  assign term = (cnt_q == half - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (term) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rise_o = run_i && term && !mdc_q;
  assign fall_o = run_i && term && mdc_q;
  assign mdc_o  = mdc_q && run_i;

  p_half_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q < half);
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
#(
  parameter int LEN  = FRAME_LEN,
  parameter int DW   = DATA_W,
  parameter int PW   = PHY_W,
  parameter int RW   = FREG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic          wr_i,
  input  logic [PW-1:0] phy_i,
  input  logic [RW-1:0] reg_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          mdio_i,
  output logic          busy_o,
  output logic          mdio_o,
  output logic          oe_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o
);
  localparam int PRE_LEN = LEN - (6 + PW + RW + DW);
  localparam int IDX_W   = $clog2(LEN);
  localparam int TA_IDX  = LEN - DW - 2;
  localparam int DAT_IDX = LEN - DW;

  logic [LEN-1:0]   tx_q, frame;
  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0]    rx_q;
  logic             busy_q, wr_q, last;

  assign frame = {{PRE_LEN{1'b1}}, 2'b01, wr_i ? 2'b01 : 2'b10, phy_i, reg_i,
                  wr_i ? 2'b10 : 2'b11, wr_i ? wdata_i : {DW{1'b1}}};
  assign last  = (idx_q == IDX_W'(LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      tx_q   <= '1;
      idx_q  <= '0;
      rx_q   <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      wr_q   <= wr_i;
      tx_q   <= frame;
      idx_q  <= '0;
      rx_q   <= '0;
    end else if (busy_q) begin
      if (fall_i) begin
        tx_q  <= {tx_q[LEN-2:0], 1'b1};
        idx_q <= idx_q + 1'b1;
        if (last) busy_q <= 1'b0;
      end
      if (rise_i && !wr_q && idx_q >= IDX_W'(DAT_IDX))
        rx_q <= {rx_q[DW-2:0], mdio_i};
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = busy_q && fall_i && last;
  assign oe_o    = busy_q && (wr_q || idx_q < IDX_W'(TA_IDX));
  assign mdio_o  = busy_q ? tx_q[LEN-1] : 1'b1;
  assign rdata_o = rx_q;

  p_hold_while_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !fall_i && !start_i && !abort_i |=> $stable(mdio_o) && $stable(oe_o));
endmodule

// File: rtl/mdio_mgmt_top.sv
module mdio_mgmt_top
  import mdio_pkg::*;
#(
  parameter int                ADDR_W   = 3,
  parameter logic [ADDR_W-1:0] CMD_OFF  = 3'h0,
  parameter logic [ADDR_W-1:0] DATA_OFF = 3'h4,
  parameter logic [CODE_W-1:0] DEF_CODE = 3'd3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  localparam int BC_W = $clog2(FRAME_LEN * MAX_DIV + 1);

  logic              wr_q;
  logic [PHY_W-1:0]  phy_q;
  logic [REG_W-1:0]  reg_q;
  logic [CODE_W-1:0] code_q;
  logic [DATA_W-1:0] data_q, rx_data;
  logic              cmd_wr, data_wr, abort, start, busy, done, rise, fall;
  logic [BUS_W-1:0]  cmd_word;
  logic              unused_wdata;

  assign cmd_wr  = bus_sel_i && bus_wr_i && (bus_addr_i == CMD_OFF);
  assign data_wr = bus_sel_i && bus_wr_i && (bus_addr_i == DATA_OFF);
  assign abort   = cmd_wr && bus_wdata_i[ABORT_BIT];
  assign start   = cmd_wr && bus_wdata_i[BUSY_BIT] && !bus_wdata_i[ABORT_BIT] && !busy;
  assign unused_wdata = ^{bus_wdata_i[BUS_W-1:CODE_LSB+CODE_W],
                          bus_wdata_i[CODE_LSB-1:PHY_LSB+PHY_W],
                          bus_wdata_i[PHY_LSB-1:REG_LSB+REG_W],
                          bus_wdata_i[REG_LSB-1:ABORT_BIT+1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= 1'b0;
      phy_q  <= '0;
      reg_q  <= '0;
      code_q <= DEF_CODE;
    end else if (abort) begin
      wr_q   <= 1'b0;
      phy_q  <= '0;
      reg_q  <= '0;
      code_q <= DEF_CODE;
    end else if (cmd_wr && !busy) begin
      wr_q   <= bus_wdata_i[DIR_BIT];
      phy_q  <= bus_wdata_i[PHY_LSB +: PHY_W];
      reg_q  <= bus_wdata_i[REG_LSB +: REG_W];
      code_q <= bus_wdata_i[CODE_LSB +: CODE_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              data_q <= '0;
    else if (done && !wr_q)   data_q <= rx_data;
    else if (data_wr)         data_q <= bus_wdata_i[DATA_W-1:0];
  end

  always_comb begin
    cmd_word = '0;
    cmd_word[BUSY_BIT]               = busy;
    cmd_word[DIR_BIT]                = wr_q;
    cmd_word[REG_LSB +: REG_W]       = reg_q;
    cmd_word[PHY_LSB +: PHY_W]       = phy_q;
    cmd_word[CODE_LSB +: CODE_W]     = code_q;
    if (bus_addr_i == CMD_OFF)       bus_rdata_o = cmd_word;
    else if (bus_addr_i == DATA_OFF) bus_rdata_o = {{(BUS_W-DATA_W){1'b0}}, data_q};
    else                             bus_rdata_o = '0;
  end

  mdio_clkgen u_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .code_i (code_q),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_shifter u_shifter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .abort_i (abort),
    .wr_i    (bus_wdata_i[DIR_BIT]),
    .phy_i   (bus_wdata_i[PHY_LSB +: PHY_W]),
    .reg_i   (bus_wdata_i[REG_LSB +: FREG_W]),
    .wdata_i (data_q),
    .rise_i  (rise),
    .fall_i  (fall),
    .mdio_i  (mdio_i),
    .busy_o  (busy),
    .mdio_o  (mdio_o),
    .oe_o    (mdio_oe_o),
    .done_o  (done),
    .rdata_o (rx_data)
  );

  // busy-time watch for the bounded-completion property
  logic [BC_W-1:0] busy_cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   busy_cyc_q <= '0;
    else if (busy) busy_cyc_q <= busy_cyc_q + 1'b1;
    else           busy_cyc_q <= '0;
  end

  p_bounded_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> busy_cyc_q < BC_W'(FRAME_LEN * MAX_DIV));
  p_mdc_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdc_o);
  p_start_preamble_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> mdio_oe_o && mdio_o);
  p_ignore_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && cmd_wr && !bus_wdata_i[ABORT_BIT] && !done |=>
      busy && $stable({wr_q, phy_q, reg_q, code_q}));
  p_abort_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort |=> !busy && !mdc_o && !mdio_oe_o);
endmodule

// File: tb/mdio_mgmt_top_tb.sv
module mdio_mgmt_top_tb;
  logic        clk = 0, rst_n = 0;
  logic        sel = 0, wr = 0;
  logic [2:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        mdc, mdio_out, oe, mdio_in;

  int checks = 0, errors = 0, cyc = 0, ncyc = 0;
  int rises = 0, last_rise = 0, exp_div = 16;
  logic [15:0] phy_val = 0;
  logic [2:0]  exp_q[$];
  logic        prev_mdc = 0, prev_mdio = 1, prev_oe = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  mdio_mgmt_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .mdc_o(mdc), .mdio_o(mdio_out), .mdio_oe_o(oe), .mdio_i(mdio_in));

  // PHY model: data bit for the next rise, updated after each rise
  always_comb mdio_in = (rises >= 48 && rises < 64) ? phy_val[63 - rises] : 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  function automatic int tdiv(input int code);
    case (code)
      0: return 42; 1: return 62; 2: return 16; 3: return 26; 4: return 102;
      default: return 124;
    endcase
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    ncyc++;
    if (mdc && !prev_mdc) begin
      if (exp_q.size() == 0) chk(0, "R5 unexpected MDC rise", rises, -1);
      else begin
        logic [2:0] e;
        e = exp_q.pop_front();
        chk(oe == e[1], "R3/R4 output enable", oe, e[1]);
        if (e[2]) chk(mdio_out == e[0], "R3 frame bit", rises, e[0]);
      end
      if (rises == 1) chk(ncyc - last_rise == exp_div, "R6 MDC period", ncyc - last_rise, exp_div);
      last_rise = ncyc;
      rises++;
    end
    if (!mdc && prev_mdc && rises == 1)
      chk(ncyc - last_rise == exp_div / 2, "R6 MDC high time", ncyc - last_rise, exp_div / 2);
    if (mdc && prev_mdc && (mdio_out !== prev_mdio || oe !== prev_oe))
      chk(0, "R5 MDIO moved while MDC high", mdio_out, prev_mdio);
    prev_mdc = mdc; prev_mdio = mdio_out; prev_oe = oe;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    sel = 1; wr = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    sel = 0; wr = 0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] r;
    n = 0;
    bus_rd(3'h0, r);
    while (r[0]) begin
      @(posedge clk); #1;
      n++;
      bus_rd(3'h0, r);
    end
  endtask

  function automatic logic [31:0] cmd(input int code, input int phy, input int rg,
                                      input bit w, input bit go);
    return (32'(code) << 20) | (32'(phy) << 12) | (32'(rg) << 4) | (32'(w) << 1) | 32'(go);
  endfunction

  task automatic push_frame(input bit w, input logic [4:0] phy, input logic [6:0] rg,
                            input logic [15:0] d);
    logic [63:0] f;
    f = {32'hFFFF_FFFF, 2'b01, w ? 2'b01 : 2'b10, phy, rg[4:0], w ? 2'b10 : 2'b11, d};
    for (int i = 63; i >= 0; i--) begin
      if (w || i > 17) exp_q.push_back({1'b1, 1'b1, f[i]});
      else             exp_q.push_back({1'b0, 1'b0, 1'b0});
    end
  endtask

  task automatic start_txn(input int code, input logic [4:0] phy, input logic [6:0] rg,
                           input bit w, input logic [15:0] d, input logic [15:0] pv);
    exp_div = tdiv(code);
    phy_val = pv;
    rises = 0;
    if (w) bus_wr(3'h4, {16'h0, d});
    push_frame(w, phy, rg, d);
    bus_wr(3'h0, cmd(code, phy, rg, w, 1));
  endtask

  initial begin
    logic [31:0] r;
    int n;
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    @(posedge clk); #1;

    // R1 reset state
    bus_rd(3'h0, r); chk(r == 32'h0030_0000, "R1 command reset", r, 32'h0030_0000);
    bus_rd(3'h4, r); chk(r == 0, "R1 data reset", r, 0);
    chk(!mdc && !oe, "R1 MDC/OE idle", {mdc, oe}, 0);

    // R2 field write and readback, stray bits dropped, no start
    bus_wr(3'h0, 32'h0021_52A2 | 32'hFF8E_0808);
    bus_rd(3'h0, r); chk(r == 32'h0021_52A2, "R2 field readback", r, 32'h0021_52A2);
    repeat (40) @(posedge clk); #1;
    chk(!mdc, "R2 no frame without start", mdc, 0);

    // R3 write frame, /16, reg field truncated to 5 bits in frame
    start_txn(2, 5'h15, 7'h6A, 1, 16'hA5C3, 0);
    wait_idle(n);
    chk(n == 64 * 16, "R7 write duration", n, 64 * 16);
    chk(exp_q.size() == 0, "R3 all bits sent", exp_q.size(), 0);
    chk(!mdc, "R5 MDC low after frame", mdc, 0);

    // R4 read frame, /26, PHY answers
    start_txn(3, 5'h01, 7'h02, 0, 0, 16'h3C5A);
    wait_idle(n);
    chk(n == 64 * 26, "R7 read duration", n, 64 * 26);
    bus_rd(3'h4, r); chk(r == 32'h3C5A, "R4 captured data", r, 32'h3C5A);
    start_txn(2, 5'h1F, 7'h1F, 0, 0, 16'h8001);
    wait_idle(n);
    bus_rd(3'h4, r); chk(r == 32'h8001, "R4 captured edge bits", r, 32'h8001);

    // R6 every divider code including reserved
    for (int c = 0; c < 8; c++) begin
      start_txn(c, 5'(c), 7'(c * 3), 1, 16'(c * 16'h1111), 0);
      wait_idle(n);
      chk(n == 64 * tdiv(c), $sformatf("R6 R7 duration code %0d", c), n, 64 * tdiv(c));
    end

    // R8 command while busy ignored
    start_txn(2, 5'h03, 7'h05, 1, 16'h0F0F, 0);
    repeat (200) @(posedge clk);
    bus_wr(3'h0, cmd(0, 5'h1F, 7'h7F, 0, 1));
    bus_rd(3'h0, r);
    chk(r == (cmd(2, 3, 5, 1, 1)), "R8 fields held while busy", r, cmd(2, 3, 5, 1, 1));
    wait_idle(n);
    chk(exp_q.size() == 0, "R8 frame unaffected", exp_q.size(), 0);
    repeat (40) @(posedge clk); #1;
    chk(!mdc, "R8 no second frame", mdc, 0);

    // R9 data write during frame
    start_txn(2, 5'h0A, 7'h0B, 1, 16'h1234, 0);
    repeat (300) @(posedge clk);
    bus_wr(3'h4, 32'h0000_FFFF);
    wait_idle(n);
    chk(exp_q.size() == 0, "R9 frame bits kept", exp_q.size(), 0);
    bus_rd(3'h4, r); chk(r == 32'hFFFF, "R9 data holds last write", r, 32'hFFFF);

    // R10 abort with start also set
    start_txn(0, 5'h11, 7'h22, 1, 16'hBEEF, 0);
    repeat (1000) @(posedge clk);
    bus_wr(3'h0, 32'h0000_0005);
    exp_q.delete();
    bus_rd(3'h0, r); chk(r == 32'h0030_0000, "R10 fields reset, idle", r, 32'h0030_0000);
    chk(!mdc && !oe, "R10 MDC/OE low", {mdc, oe}, 0);
    repeat (500) @(posedge clk); #1;
    chk(!mdc, "R10 stays idle", mdc, 0);
    start_txn(3, 5'h02, 7'h03, 1, 16'h5555, 0);
    wait_idle(n);
    chk(n == 64 * 26 && exp_q.size() == 0, "R10 frame after abort", n, 64 * 26);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule